// File: doc/BRIEF.md
# Clock and Power Sequencing Controller

This block owns the clock source choice and the low-power states of a small processor core. Software writes two 16-bit control words, one for power and one for the PLL, and the block turns them into a slow/PLL clock select, a global clock gate, a processor clock gate, peripheral power-down lines, an input-buffer power-down and a PLL enable. The analog PLL and the oscillator are outside the block: the PLL appears only as a lock flag input. The settling time of the input buffer is modelled by an internal countdown.

The hardware enforces the legal order of power transitions:
- The PLL may only be turned off once the slow clock is selected and in effect.
- The input buffer may only be powered down once the PLL is off.
- A full clock stop requires the PLL to be off.
- Moving onto the PLL clock requires the PLL to be on, armed for selection and locked.

Any write that breaks one of these rules is dropped as a whole and raises a sticky error flag. A full stop or a processor nap is left only through an interrupt pin or reset. An INT0 wake also drops the INT0 wake-enable and the buffer power-down, so that the restart order can begin at once.

A change of clock source reaches the select output, and the read-back of the power word, a fixed number of cycles after the write. The actual glitch-free multiplexing of the two clocks happens downstream on that select.

Top module: `clk_power_sequencer`

## Requirements
- R1: After reset the power read-back is 0x4000 and the PLL read-back is 0x0000. In that state `useSlowClk`, `allClkEn`, `coreClkEn` and `bufReady` are 1, and `pllEn`, `bufPd`, `periphPd` and `seqErr` are 0.
- R2: Power word fields are:
  - bit 15: buffer power-down, drives `bufPd`.
  - bit 14: slow clock select.
  - bit 13: full clock stop.
  - bit 12: INT0 wake enable.
  - bits 7:4: peripheral power-downs, drive `periphPd`.
  - bit 0: processor nap.
  - All other bits read 0.
  The PLL word stores all 16 bits and reads them back unchanged while the PLL is off. Its bit 15 is the PLL enable (drives `pllEn`) and its bit 14 arms PLL selection.
- R3: A legal change of the slow select bit appears on `useSlowClk` and on power read-back bit 14 exactly SRC_STAGES (default 2) cycles after the write edge. Before that, both still show the old source.
- R4: A power write that clears the slow select bit is legal only if the PLL enable, the PLL select bit and `pllLock` are all 1.
- R5: A PLL write that clears the enable bit is legal only if the slow clock is both requested and active. A PLL write that clears the select bit while the PLL clock is requested is illegal.
- R6: Setting the buffer power-down bit is legal only while the PLL is disabled.
- R7: Setting the PLL enable is legal only while `bufPd` is 0 and `bufReady` is 1.
- R8: `bufReady` drops in the cycle after `bufPd` rises. It returns to 1 exactly STABLE_CYCLES (default 16) cycles after `bufPd` falls.
- R9: With the stop bit set, both `allClkEn` and `coreClkEn` are 0. Setting the stop bit is legal only while the PLL is disabled.
- R10: With the nap bit set, `coreClkEn` is 0 and `allClkEn` stays 1.
- R11: Wake behaviour:
  - While stopped or napping, a pulse on `int0Pin` or `int1Pin` clears the stop and nap bits at the next edge.
  - An INT0 wake also clears bits 12 and 15; an INT1 wake keeps them.
  - Writes made while stopped or napping are ignored and raise no error.
  - Pin pulses while awake change nothing.
- R12: An illegal write leaves both words unchanged and sets `seqErr`, which then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock of the controller |
| rstN | input | 1 | Asynchronous active-low reset (the reset pin) |
| wrEn | input | 1 | Write strobe for one cycle |
| wrSel | input | 1 | Write target: 0 power word, 1 PLL word |
| wrData | input | 16 | Write data |
| pllLock | input | 1 | PLL lock flag |
| int0Pin | input | 1 | Interrupt 0 wake pin |
| int1Pin | input | 1 | Interrupt 1 wake pin |
| powerRd | output | 16 | Power word read-back, bit 14 shows the active source |
| pllRd | output | 16 | PLL word read-back |
| useSlowClk | output | 1 | 1: slow clock active, 0: PLL clock active |
| allClkEn | output | 1 | Global clock gate |
| coreClkEn | output | 1 | Processor clock gate |
| periphPd | output | 4 | Peripheral power-down lines |
| bufPd | output | 1 | Input-buffer power-down |
| bufReady | output | 1 | Input buffer stable |
| pllEn | output | 1 | PLL enable |
| seqErr | output | 1 | Sticky ordering-violation flag |

## Verification
The assertions watch the ordering invariants on every cycle. The PLL only switches off while the slow clock is active, and the buffer only powers down with the PLL off. The PLL only comes up on a ready buffer, the PLL clock is only active with the PLL on, and a stop is only left after a pin event. The error flag never drops.

Only the bench scenarios can show the exact timing: the two-cycle source latency and the sixteen-cycle buffer countdown. They also show that each rejected write really leaves the words untouched, the field layout under sweeps, and the different clean-up done by an INT0 wake versus an INT1 wake.

// File: rtl/clk_pwr_pkg.sv
package clk_pwr_pkg;
  localparam int REG_W     = 16;
  localparam int BIT_XTL   = 15;
  localparam int BIT_SLOW  = 14;
  localparam int BIT_STOP  = 13;
  localparam int BIT_I0EN  = 12;
  localparam int BIT_NAP   = 0;
  localparam int PER_LO    = 4;
  localparam int PER_N     = 4;
  localparam int BIT_PEN   = 15;
  localparam int BIT_PSEL  = 14;

  typedef struct packed {
    logic loadPower;
    logic loadPll;
    logic wake;
    logic wakeInt0;
    logic setErr;
  } seqStrobe_t;
endpackage

// File: rtl/clk_pwr_ctrl.sv
module clk_pwr_ctrl
  import clk_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic       wrXtl,
  input  logic       wrSlow,
  input  logic       wrStop,
  input  logic       wrPllEn,
  input  logic       wrPllSel,
  input  logic       pllLock,
  input  logic       int0Pin,
  input  logic       int1Pin,
  input  logic       xtlQ,
  input  logic       slowReqQ,
  input  logic       srcSettled,
  input  logic       stopQ,
  input  logic       napQ,
  input  logic       pllEnQ,
  input  logic       pllSelQ,
  input  logic       bufStable,
  output seqStrobe_t strobe
);
  logic coreHalted;
  logic wakeEvt;
  logic acceptWr;
  logic pwrBad;
  logic pllBad;

  always_comb begin
    coreHalted = stopQ || napQ;
    wakeEvt    = coreHalted && (int0Pin || int1Pin);
    acceptWr   = wrEn && !coreHalted;

    // power word legality: PLL source needs a locked, armed PLL;
    // buffer and stop need the PLL off
    pwrBad = (!wrSlow && slowReqQ && !(pllEnQ && pllSelQ && pllLock))
          || (wrXtl && !xtlQ && pllEnQ)
          || (wrStop && pllEnQ);

    // PLL word legality: off only on a settled slow clock,
    // on only with a stable buffer, no disarm while PLL clock requested
    pllBad = (!wrPllEn && pllEnQ && !(slowReqQ && srcSettled))
          || (wrPllEn && !pllEnQ && (xtlQ || !bufStable))
          || (!wrPllSel && !slowReqQ);

    strobe.wake      = wakeEvt;
    strobe.wakeInt0  = wakeEvt && int0Pin;
    strobe.loadPower = acceptWr && !wrSel && !pwrBad;
    strobe.loadPll   = acceptWr &&  wrSel && !pllBad;
    strobe.setErr    = acceptWr && (wrSel ? pllBad : pwrBad);
  end

  // R4: moving onto the PLL clock only ever accepted with lock present
  p_lock_for_pll_src_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadPower && !wrSlow && slowReqQ) |-> (pllLock && pllEnQ));

  // R11: nothing is loaded while the core clock is halted
  p_halt_blocks_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stopQ || napQ) |-> !(strobe.loadPower || strobe.loadPll || strobe.setErr));
endmodule

// File: rtl/clk_pwr_datapath.sv
module clk_pwr_datapath
  import clk_pwr_pkg::*;
#(
  parameter int STABLE_CYCLES = 16,
  parameter int SRC_STAGES    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [REG_W-1:0] wrData,
  output logic             xtlQ,
  output logic             slowReqQ,
  output logic             slowActQ,
  output logic             srcSettled,
  output logic             stopQ,
  output logic             napQ,
  output logic             int0EnQ,
  output logic [PER_N-1:0] periphQ,
  output logic [REG_W-1:0] pllQ,
  output logic             errQ,
  output logic             bufStable
);
  localparam int CNT_W = $clog2(STABLE_CYCLES + 1);

  logic [CNT_W-1:0] stableCnt;
  logic             srcPipe [SRC_STAGES];

  // power word fields; wake has priority (writes are blocked while halted)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xtlQ     <= 1'b0;
      slowReqQ <= 1'b1;
      stopQ    <= 1'b0;
      int0EnQ  <= 1'b0;
      periphQ  <= '0;
      napQ     <= 1'b0;
    end else if (strobe.wake) begin
      stopQ <= 1'b0;
      napQ  <= 1'b0;
      if (strobe.wakeInt0) begin
        int0EnQ <= 1'b0;
        xtlQ    <= 1'b0;
      end
    end else if (strobe.loadPower) begin
      xtlQ     <= wrData[BIT_XTL];
      slowReqQ <= wrData[BIT_SLOW];
      stopQ    <= wrData[BIT_STOP];
      int0EnQ  <= wrData[BIT_I0EN];
      periphQ  <= wrData[PER_LO +: PER_N];
      napQ     <= wrData[BIT_NAP];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pllQ <= '0;
    else if (strobe.loadPll) pllQ <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              errQ <= 1'b0;
    else if (strobe.setErr) errQ <= 1'b1;
  end

  // source select pipeline feeding the downstream glitch-free mux
  for (genvar g = 0; g < SRC_STAGES; g++) begin : g_src
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) srcPipe[g] <= 1'b1;
        else       srcPipe[g] <= slowReqQ;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) srcPipe[g] <= 1'b1;
        else       srcPipe[g] <= srcPipe[g-1];
      end
    end
  end

  always_comb begin
    srcSettled = 1'b1;
    for (int i = 0; i < SRC_STAGES; i++) begin
      if (srcPipe[i] != slowReqQ) srcSettled = 1'b0;
    end
  end

  assign slowActQ = srcPipe[SRC_STAGES-1];

  // input buffer settle model: held full while powered down
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                stableCnt <= '0;
    else if (xtlQ)            stableCnt <= CNT_W'(STABLE_CYCLES);
    else if (stableCnt != '0) stableCnt <= stableCnt - 1'b1;
  end

  assign bufStable = !xtlQ && (stableCnt == '0);

  p_pll_off_on_slow_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pllQ[BIT_PEN]) |-> (slowActQ && $past(slowActQ)));

  p_xtl_needs_pll_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xtlQ) |-> !pllQ[BIT_PEN]);

  p_pll_on_needs_buf_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pllQ[BIT_PEN]) |-> $past(bufStable));

  p_pll_src_needs_en_r4: assert property (@(posedge clk) disable iff (!rstN)
    !slowActQ |-> pllQ[BIT_PEN]);

  p_stop_pll_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    stopQ |-> !pllQ[BIT_PEN]);

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    $past(errQ) |-> errQ);
endmodule

// File: rtl/clk_power_sequencer.sv
module clk_power_sequencer
  import clk_pwr_pkg::*;
#(
  parameter int STABLE_CYCLES = 16,
  parameter int SRC_STAGES    = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic [15:0] wrData,
  input  logic        pllLock,
  input  logic        int0Pin,
  input  logic        int1Pin,
  output logic [15:0] powerRd,
  output logic [15:0] pllRd,
  output logic        useSlowClk,
  output logic        allClkEn,
  output logic        coreClkEn,
  output logic [3:0]  periphPd,
  output logic        bufPd,
  output logic        bufReady,
  output logic        pllEn,
  output logic        seqErr
);
  seqStrobe_t       strobe;
  logic             xtlQ, slowReqQ, slowActQ, srcSettled;
  logic             stopQ, napQ, int0EnQ, errQ, bufStable;
  logic [PER_N-1:0] periphQ;
  logic [REG_W-1:0] pllQ;

  clk_pwr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .wrXtl(wrData[BIT_XTL]), .wrSlow(wrData[BIT_SLOW]), .wrStop(wrData[BIT_STOP]),
    .wrPllEn(wrData[BIT_PEN]), .wrPllSel(wrData[BIT_PSEL]),
    .pllLock(pllLock), .int0Pin(int0Pin), .int1Pin(int1Pin),
    .xtlQ(xtlQ), .slowReqQ(slowReqQ), .srcSettled(srcSettled),
    .stopQ(stopQ), .napQ(napQ), .pllEnQ(pllQ[BIT_PEN]), .pllSelQ(pllQ[BIT_PSEL]),
    .bufStable(bufStable), .strobe(strobe)
  );

  clk_pwr_datapath #(.STABLE_CYCLES(STABLE_CYCLES), .SRC_STAGES(SRC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .xtlQ(xtlQ), .slowReqQ(slowReqQ), .slowActQ(slowActQ), .srcSettled(srcSettled),
    .stopQ(stopQ), .napQ(napQ), .int0EnQ(int0EnQ), .periphQ(periphQ),
    .pllQ(pllQ), .errQ(errQ), .bufStable(bufStable)
  );

  assign powerRd    = {xtlQ, slowActQ, stopQ, int0EnQ, 4'b0000, periphQ, 3'b000, napQ};
  assign pllRd      = pllQ;
  assign useSlowClk = slowActQ;
  assign allClkEn   = !stopQ;
  assign coreClkEn  = !stopQ && !napQ;
  assign periphPd   = periphQ;
  assign bufPd      = xtlQ;
  assign bufReady   = bufStable;
  assign pllEn      = pllQ[BIT_PEN];
  assign seqErr     = errQ;

  // R11: a full stop is only left after an interrupt pin event
  p_stop_exit_by_pin_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stopQ) |-> $past(int0Pin || int1Pin));
endmodule

// File: tb/clk_power_sequencer_tb.sv
module clk_power_sequencer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrSel = 1'b0;
  logic [15:0] wrData = '0;
  logic        pllLock = 1'b0, int0Pin = 1'b0, int1Pin = 1'b0;
  logic [15:0] powerRd, pllRd;
  logic        useSlowClk, allClkEn, coreClkEn, bufPd, bufReady, pllEn, seqErr;
  logic [3:0]  periphPd;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  localparam int STABLE = 16;

  always #2.5 clk = ~clk;

  clk_power_sequencer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .pllLock(pllLock), .int0Pin(int0Pin), .int1Pin(int1Pin),
    .powerRd(powerRd), .pllRd(pllRd), .useSlowClk(useSlowClk),
    .allClkEn(allClkEn), .coreClkEn(coreClkEn), .periphPd(periphPd),
    .bufPd(bufPd), .bufReady(bufReady), .pllEn(pllEn), .seqErr(seqErr)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulse(input logic i0, input logic i1);
    @(negedge clk);
    int0Pin = i0; int1Pin = i1;
    @(negedge clk);
    int0Pin = 1'b0; int1Pin = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic resetCheck(input string tag);
    chk({tag, " powerRd"}, powerRd, 16'h4000);
    chk({tag, " pllRd"}, pllRd, 16'h0000);
    chk({tag, " gates"}, {12'h0, useSlowClk, allClkEn, coreClkEn, bufReady}, 16'h000F);
    chk({tag, " lows"}, {10'h0, pllEn, bufPd, periphPd}, 16'h0000);
    chk({tag, " seqErr"}, {15'h0, seqErr}, 16'h0000);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    resetCheck("R1 reset");

    // R2 sweep of peripheral power-down field, stray bits read 0
    for (int p = 0; p < 16; p++) begin
      wr(1'b0, 16'h4F0E | 16'(p << 4));
      chk("R2 periphPd", {12'h0, periphPd}, 16'(p));
      chk("R2 powerRd", powerRd, 16'h4000 | 16'(p << 4));
    end
    wr(1'b0, 16'h4000);
    // R2 PLL config sweep while PLL off
    for (int i = 0; i < 16; i++) begin
      logic [15:0] v;
      v = 16'((i * 16'h0731) & 16'h3FFF);
      wr(1'b1, v);
      chk("R2 pllRd", pllRd, v);
      chk("R2 pllEn off", {15'h0, pllEn}, 16'h0000);
    end
    wr(1'b1, 16'h0123);

    // R6 legal buffer power-down with PLL off, R8 ready drops
    wr(1'b0, 16'hC000);
    chk("R6 bufPd set", {15'h0, bufPd}, 16'h0001);
    chk("R8 ready low", {15'h0, bufReady}, 16'h0000);
    // R7 PLL enable with buffer down is illegal, R12 sticky error
    wr(1'b1, 16'h8123);
    chk("R7 pllEn rejected", {15'h0, pllEn}, 16'h0000);
    chk("R12 pllRd kept", pllRd, 16'h0123);
    chk("R12 seqErr set", {15'h0, seqErr}, 16'h0001);

    // R8 countdown after buffer power-up
    wr(1'b0, 16'h4000);
    chk("R8 ready low at clear", {15'h0, bufReady}, 16'h0000);
    for (int j = 1; j <= STABLE; j++) begin
      @(negedge clk);
      if (j == STABLE - 1) chk("R8 ready one early", {15'h0, bufReady}, 16'h0000);
      if (j == STABLE)     chk("R8 ready on time", {15'h0, bufReady}, 16'h0001);
    end

    // R7 legal enable
    wr(1'b1, 16'hC123);
    chk("R7 pllEn on", {15'h0, pllEn}, 16'h0001);
    chk("R7 pllRd", pllRd, 16'hC123);
    // R6 illegal buffer down with PLL on
    wr(1'b0, 16'hC000);
    chk("R6 bufPd rejected", {15'h0, bufPd}, 16'h0000);
    chk("R12 powerRd kept", powerRd, 16'h4000);
    // R9 illegal stop with PLL on
    wr(1'b0, 16'h6000);
    chk("R9 stop rejected", {14'h0, allClkEn, coreClkEn}, 16'h0003);

    // R4 switch to PLL without lock is illegal
    wr(1'b0, 16'h0000);
    idle(3);
    chk("R4 no lock slow kept", {15'h0, useSlowClk}, 16'h0001);
    chk("R4 no lock powerRd", powerRd, 16'h4000);
    // R3 legal switch with lock, two-cycle latency
    pllLock = 1'b1;
    wr(1'b0, 16'h0000);
    chk("R3 old source k", {15'h0, useSlowClk}, 16'h0001);
    @(negedge clk);
    chk("R3 old source k+1", {14'h0, useSlowClk, powerRd[14]}, 16'h0003);
    @(negedge clk);
    chk("R3 new source k+2", {14'h0, useSlowClk, powerRd[14]}, 16'h0000);

    // R5 illegal disable on PLL clock, illegal disarm
    wr(1'b1, 16'h0123);
    chk("R5 disable rejected", {15'h0, pllEn}, 16'h0001);
    wr(1'b1, 16'h8123);
    chk("R5 disarm rejected", pllRd, 16'hC123);
    // R5 back to slow, disable while change pending is illegal
    wr(1'b0, 16'h4000);
    wr(1'b1, 16'h0123);
    chk("R5 pending disable rejected", {15'h0, pllEn}, 16'h0001);
    idle(2);
    chk("R3 back on slow", {15'h0, useSlowClk}, 16'h0001);
    wr(1'b1, 16'h0123);
    chk("R5 legal disable", {15'h0, pllEn}, 16'h0000);
    chk("R2 cfg held off", pllRd, 16'h0123);
    pllLock = 1'b0;

    // R10 nap, writes ignored while halted, INT1 wake
    wr(1'b0, 16'h4001);
    chk("R10 nap gates", {14'h0, allClkEn, coreClkEn}, 16'h0002);
    wr(1'b0, 16'h4010);
    chk("R11 write ignored in nap", {12'h0, periphPd}, 16'h0000);
    pulse(1'b0, 1'b1);
    chk("R11 nap wake powerRd", powerRd, 16'h4000);
    chk("R11 nap wake gates", {14'h0, allClkEn, coreClkEn}, 16'h0003);
    // R11 pins while awake do nothing
    wr(1'b0, 16'h5000);
    pulse(1'b1, 1'b1);
    chk("R11 awake pin no effect", powerRd, 16'h5000);

    // R9 full stop, INT0 wake clears enable and buffer down
    wr(1'b0, 16'hF000);
    chk("R9 stop gates", {13'h0, allClkEn, coreClkEn, bufPd}, 16'h0001);
    idle(4);
    chk("R9 stop held", {15'h0, allClkEn}, 16'h0000);
    pulse(1'b1, 1'b0);
    chk("R11 int0 wake powerRd", powerRd, 16'h4000);
    chk("R11 int0 wake gates", {13'h0, allClkEn, coreClkEn, bufPd}, 16'h0006);
    chk("R8 ready after wake", {15'h0, bufReady}, 16'h0000);
    idle(STABLE + 1);
    chk("R8 ready later", {15'h0, bufReady}, 16'h0001);
    // R11 INT1 wake keeps INT0 enable
    wr(1'b0, 16'h7000);
    chk("R9 stop again", {15'h0, allClkEn}, 16'h0000);
    pulse(1'b0, 1'b1);
    chk("R11 int1 wake powerRd", powerRd, 16'h5000);
    chk("R12 still sticky", {15'h0, seqErr}, 16'h0001);

    // R1 reset from an active state
    wr(1'b0, 16'h40A0);
    wr(1'b1, 16'h8055);
    chk("R7 enable before reset", {15'h0, pllEn}, 16'h0001);
    @(negedge clk);
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    idle(1);
    resetCheck("R1 re-reset");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule